// File: doc/BRIEF.md
# Lookup-Table Pattern and Edge Trigger

This block is the trigger decision unit of a 16-channel logic analyzer. Every accepted 16-bit sample is split into four 4-bit groups, and each group's bits index a 16-entry truth table. The four lookups of one table set are ANDed together. Three table sets exist. The first implements a value/mask pattern match. The other two each isolate one channel and act as edge detectors. A 16-entry glue table is indexed by the previous and current outputs of the two detectors. It decides which transitions count. The trigger fires when the pattern match and the glue result are true for the same sample.

The host fills all three table sets in sixteen steps. In each step it first writes a staging word that holds one column: the entry at one index, for every group of every set. It then writes a select byte carrying a commit tag and that index. The glue table is written whole in one access. Arming clears the fired state and restarts the sample count. The first matching sample gives a one-cycle pulse, latches a fired flag and records its zero-based position within the capture.

Top module: `quad_lut_trigger`

## Requirements
- R1: After reset `trig_pulse` and `fired` are 0 and the unit is disarmed. The value/mask tables reset to all ones, the edge tables to all zeros and the glue table to all ones, so after an arm the first valid sample fires at position 0.
- R2: A select write whose bits [7:4] equal 4'h3 commits the staging word at the table index in bits [3:0]. Staging bit g goes to value/mask group g, bit 4+g to edge set 0 group g, and bit 8+g to edge set 1 group g. Group g covers sample bits [4g+3:4g].
- R3: A select write whose bits [7:4] differ from 4'h3 changes no table entry.
- R4: The pattern result is the AND over the four groups of each group's value/mask table entry, indexed by that group's sample bits.
- R5: The glue index is {det1_cur, det1_prev, det0_cur, det0_prev}, where det_k is the AND of the four lookups of edge set k. For the first valid sample after an arm, prev is taken equal to cur, so no transition is seen.
- R6: A valid sample fires the trigger only when the pattern result and the glue entry are both 1.
- R7: `trig_pulse` is high for exactly the one cycle after the clock edge that accepts the firing sample, and `fired` rises in that same cycle.
- R8: Only the first match after an arm fires. `fired` and `trig_pos` then hold, with no further pulses, until the next arm.
- R9: `trig_pos` is the number of valid samples accepted since the arm before the firing sample. Cycles with `smp_valid` low are neither evaluated nor counted.
- R10: An arm clears `fired` and restarts both the sample count and the transition history. A sample presented in the arm cycle is ignored.
- R11: A glue write replaces all 16 glue entries with `glue_data`. Bit i is the entry for glue index i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stg_we | input | 1 | Write the staging column |
| stg_data | input | 12 | Staging column, one bit per group of each table set |
| sel_we | input | 1 | Write the select byte |
| sel_data | input | 8 | Commit tag in [7:4], table index in [3:0] |
| glue_we | input | 1 | Write the glue table |
| glue_data | input | 16 | New glue table contents |
| arm | input | 1 | Re-arm the trigger |
| smp_valid | input | 1 | A new sample is present |
| smp_data | input | 16 | Sample, one bit per channel |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| fired | output | 1 | Trigger has fired since the last arm |
| trig_pos | output | 16 | Position of the firing sample |

## Verification
A wrong table entry, whether from a misplaced staging bit, a bad index decode or a commit on the wrong tag, shows up on `trig_pulse` one cycle after the first sample that uses the entry. The directed sample patterns are chosen so that each group, each set and the tag decode change the outcome of some sample. A broken transition history shows as a pulse on a steady level, or as a missing pulse on a real edge, one cycle after the sample concerned. A broken position counter or a broken fired latch shows in `trig_pos` right after the pulse, or when later matching samples fail to leave it unchanged.

// File: rtl/qlt_pkg.sv
package qlt_pkg;
   // two edge detectors, each contributes a previous and a current bit
   localparam int unsigned DET_NUM    = 2;
   localparam int unsigned GLUE_IDX_W = 2 * DET_NUM;
   localparam int unsigned GLUE_DEPTH = 1 << GLUE_IDX_W;
   // table sets: pattern match first, then the edge detectors
   localparam int unsigned SET_NUM    = 1 + DET_NUM;
   localparam int unsigned SEL_W      = 8;
   localparam logic [3:0]  SEL_TAG    = 4'h3;

   typedef struct packed {
      logic cur;
      logic prev;
   } det_pair_t;
endpackage

// File: rtl/qlt_table_set.sv
module qlt_table_set #(
   parameter int unsigned NUM_GROUPS = 4,
   parameter int unsigned GROUP_BITS = 4,
   parameter bit          RESET_ONES = 1'b1,
   localparam int unsigned DEPTH     = 1 << GROUP_BITS,
   localparam int unsigned CH        = NUM_GROUPS * GROUP_BITS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ld_en,
   input  logic [GROUP_BITS-1:0] ld_idx,
   input  logic [NUM_GROUPS-1:0] ld_col,
   input  logic [CH-1:0]         smp,
   output logic                  match
);
   localparam logic [DEPTH-1:0] RST_VAL = RESET_ONES ? {DEPTH{1'b1}} : {DEPTH{1'b0}};

   logic [NUM_GROUPS-1:0] hit;

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      logic [DEPTH-1:0]      tbl;
      logic [GROUP_BITS-1:0] nib;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tbl <= RST_VAL;
         end else if (ld_en) begin
            tbl[ld_idx] <= ld_col[g];
         end
      end

      assign nib    = smp[g*GROUP_BITS +: GROUP_BITS];
      assign hit[g] = tbl[nib];
   end

   assign match = &hit;
endmodule

// File: rtl/qlt_loader.sv
module qlt_loader
   import qlt_pkg::*;
#(
   parameter int unsigned NUM_GROUPS = 4,
   parameter int unsigned GROUP_BITS = 4,
   localparam int unsigned STG_W     = SET_NUM * NUM_GROUPS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  stg_we,
   input  logic [STG_W-1:0]      stg_data,
   input  logic                  sel_we,
   input  logic [SEL_W-1:0]      sel_data,
   output logic                  ld_en,
   output logic [GROUP_BITS-1:0] ld_idx,
   output logic [STG_W-1:0]      ld_cols
);
   logic [STG_W-1:0] stage_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else if (stg_we) begin
         stage_q <= stg_data;
      end
   end

   // commit only on the matching tag; the select carries the index
   assign ld_en   = sel_we && (sel_data[SEL_W-1 -: 4] == SEL_TAG);
   assign ld_idx  = sel_data[GROUP_BITS-1:0];
   assign ld_cols = stage_q;
endmodule

// File: rtl/qlt_glue.sv
module qlt_glue
   import qlt_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  glue_we,
   input  logic [GLUE_DEPTH-1:0] glue_data,
   input  logic [GLUE_IDX_W-1:0] idx,
   output logic                  result
);
   logic [GLUE_DEPTH-1:0] glue_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         glue_q <= '1;
      end else if (glue_we) begin
         glue_q <= glue_data;
      end
   end

   assign result = glue_q[idx];
endmodule

// File: rtl/quad_lut_trigger.sv
module quad_lut_trigger
   import qlt_pkg::*;
#(
   parameter int unsigned NUM_GROUPS = 4,
   parameter int unsigned GROUP_BITS = 4,
   parameter int unsigned POS_W      = 16,
   localparam int unsigned CH        = NUM_GROUPS * GROUP_BITS,
   localparam int unsigned STG_W     = SET_NUM * NUM_GROUPS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  stg_we,
   input  logic [STG_W-1:0]      stg_data,
   input  logic                  sel_we,
   input  logic [SEL_W-1:0]      sel_data,
   input  logic                  glue_we,
   input  logic [GLUE_DEPTH-1:0] glue_data,
   input  logic                  arm,
   input  logic                  smp_valid,
   input  logic [CH-1:0]         smp_data,
   output logic                  trig_pulse,
   output logic                  fired,
   output logic [POS_W-1:0]      trig_pos
);
   // elaboration checks on the parameters
   if (GROUP_BITS < 1 || GROUP_BITS > 4) begin : g_bad_gb
      $error("GROUP_BITS must be 1..4 to fit the select index field");
   end
   if (NUM_GROUPS < 1) begin : g_bad_ng
      $error("NUM_GROUPS must be at least 1");
   end
   if (POS_W < 1) begin : g_bad_pw
      $error("POS_W must be at least 1");
   end

   logic                  ld_en;
   logic [GROUP_BITS-1:0] ld_idx;
   logic [STG_W-1:0]      ld_cols;
   logic [SET_NUM-1:0]    set_match;

   qlt_loader #(
      .NUM_GROUPS(NUM_GROUPS),
      .GROUP_BITS(GROUP_BITS)
   ) u_loader (
      .clk      (clk),
      .rst_n    (rst_n),
      .stg_we   (stg_we),
      .stg_data (stg_data),
      .sel_we   (sel_we),
      .sel_data (sel_data),
      .ld_en    (ld_en),
      .ld_idx   (ld_idx),
      .ld_cols  (ld_cols)
   );

   // set 0 is the pattern match (resets open), sets 1.. are edge detectors
   for (genvar s = 0; s < SET_NUM; s++) begin : g_set
      qlt_table_set #(
         .NUM_GROUPS(NUM_GROUPS),
         .GROUP_BITS(GROUP_BITS),
         .RESET_ONES(s == 0)
      ) u_set (
         .clk    (clk),
         .rst_n  (rst_n),
         .ld_en  (ld_en),
         .ld_idx (ld_idx),
         .ld_col (ld_cols[s*NUM_GROUPS +: NUM_GROUPS]),
         .smp    (smp_data),
         .match  (set_match[s])
      );
   end

   // transition history and glue index
   logic                  armed_q;
   logic                  hist_q;
   logic [DET_NUM-1:0]    det_prev_q;
   det_pair_t             pair [DET_NUM];
   logic [GLUE_IDX_W-1:0] glue_idx;
   logic                  glue_res;

   for (genvar d = 0; d < DET_NUM; d++) begin : g_det
      assign pair[d].cur  = set_match[1+d];
      assign pair[d].prev = hist_q ? det_prev_q[d] : set_match[1+d];
      assign glue_idx[2*d]   = pair[d].prev;
      assign glue_idx[2*d+1] = pair[d].cur;
   end

   qlt_glue u_glue (
      .clk       (clk),
      .rst_n     (rst_n),
      .glue_we   (glue_we),
      .glue_data (glue_data),
      .idx       (glue_idx),
      .result    (glue_res)
   );

   logic             accept;
   logic             hit;
   logic [POS_W-1:0] cnt_q;
   logic [DET_NUM-1:0] det_cur;

   for (genvar d = 0; d < DET_NUM; d++) begin : g_cur
      assign det_cur[d] = set_match[1+d];
   end

   assign accept = armed_q && smp_valid && !arm;
   assign hit    = accept && !fired && set_match[0] && glue_res;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q    <= 1'b0;
         hist_q     <= 1'b0;
         det_prev_q <= '0;
         cnt_q      <= '0;
         fired      <= 1'b0;
         trig_pulse <= 1'b0;
         trig_pos   <= '0;
      end else if (arm) begin
         armed_q    <= 1'b1;
         hist_q     <= 1'b0;
         det_prev_q <= '0;
         cnt_q      <= '0;
         fired      <= 1'b0;
         trig_pulse <= 1'b0;
         trig_pos   <= '0;
      end else begin
         trig_pulse <= hit;
         if (accept) begin
            hist_q     <= 1'b1;
            det_prev_q <= det_cur;
            if (!fired) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         if (hit) begin
            fired    <= 1'b1;
            trig_pos <= cnt_q;
         end
      end
   end
endmodule

// File: rtl/quad_lut_trigger_chk.sv
module quad_lut_trigger_chk #(
   parameter int unsigned POS_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             arm,
   input logic             smp_valid,
   input logic             trig_pulse,
   input logic             fired,
   input logic [POS_W-1:0] trig_pos
);
   // R7
   pulse_sets_fired_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pulse |-> fired);

   // R7
   pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pulse |=> !trig_pulse);

   // R8
   fired_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fired && !arm) |=> fired);

   // R8
   pos_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fired && !arm) |=> $stable(trig_pos));

   // R9
   pulse_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pulse |-> $past(smp_valid));

   // R10
   arm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> (!fired && !trig_pulse));
endmodule

bind quad_lut_trigger quad_lut_trigger_chk #(.POS_W(POS_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .arm        (arm),
   .smp_valid  (smp_valid),
   .trig_pulse (trig_pulse),
   .fired      (fired),
   .trig_pos   (trig_pos)
);

// File: tb/tb_quad_lut_trigger.sv
module tb_quad_lut_trigger;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stg_we = 1'b0;
   logic [11:0] stg_data = '0;
   logic        sel_we = 1'b0;
   logic [7:0]  sel_data = '0;
   logic        glue_we = 1'b0;
   logic [15:0] glue_data = '0;
   logic        arm = 1'b0;
   logic        smp_valid = 1'b0;
   logic [15:0] smp_data = '0;
   logic        trig_pulse;
   logic        fired;
   logic [15:0] trig_pos;

   int n_chk = 0;
   int n_bad = 0;

   logic [15:0] tv [4];
   logic [15:0] te0 [4];
   logic [15:0] te1 [4];

   always #4 clk = ~clk;

   quad_lut_trigger dut (
      .clk(clk), .rst_n(rst_n), .stg_we(stg_we), .stg_data(stg_data),
      .sel_we(sel_we), .sel_data(sel_data), .glue_we(glue_we),
      .glue_data(glue_data), .arm(arm), .smp_valid(smp_valid),
      .smp_data(smp_data), .trig_pulse(trig_pulse), .fired(fired),
      .trig_pos(trig_pos)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // table entry true when every masked channel of group g equals its value
   function automatic logic [15:0] pat_tbl(logic [15:0] val, logic [15:0] msk, int g);
      logic [15:0] t;
      for (int idx = 0; idx < 16; idx++) begin
         t[idx] = 1'b1;
         for (int k = 0; k < 4; k++) begin
            if (msk[g*4+k] && (idx[k] != val[g*4+k])) t[idx] = 1'b0;
         end
      end
      return t;
   endfunction

   // glue index {c1,p1,c0,p0}
   function automatic logic [15:0] glue_of(bit rise0, bit fall1);
      logic [15:0] t;
      for (int i = 0; i < 16; i++) begin
         t[i] = (rise0 && ((i & 3) == 2)) || (fall1 && (((i >> 2) & 3) == 1));
      end
      return t;
   endfunction

   task automatic build(logic [15:0] val, logic [15:0] msk, int e0ch, int e1ch);
      for (int g = 0; g < 4; g++) begin
         tv[g]  = pat_tbl(val, msk, g);
         te0[g] = (e0ch < 0) ? 16'h0 : pat_tbl(16'(1 << e0ch), 16'(1 << e0ch), g);
         te1[g] = (e1ch < 0) ? 16'h0 : pat_tbl(16'(1 << e1ch), 16'(1 << e1ch), g);
      end
   endtask

   task automatic load_tables();
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         stg_we = 1'b1;
         for (int g = 0; g < 4; g++) begin
            stg_data[g]   = tv[g][i];
            stg_data[4+g] = te0[g][i];
            stg_data[8+g] = te1[g][i];
         end
         @(negedge clk);
         stg_we   = 1'b0;
         sel_we   = 1'b1;
         sel_data = 8'h30 | 8'(i);
         @(negedge clk);
         sel_we = 1'b0;
      end
   endtask

   task automatic set_glue(logic [15:0] v);
      @(negedge clk);
      glue_we   = 1'b1;
      glue_data = v;
      @(negedge clk);
      glue_we = 1'b0;
   endtask

   task automatic do_arm();
      @(negedge clk);
      arm = 1'b1;
      @(negedge clk);
      arm = 1'b0;
      chk("R10 fired after arm", 32'(fired), 0);
   endtask

   // present one sample, then check the pulse in the following cycle
   task automatic send(logic [15:0] d, bit vld, bit exp_pulse, string req);
      @(negedge clk);
      smp_valid = vld;
      smp_data  = d;
      @(negedge clk);
      smp_valid = 1'b0;
      chk(req, 32'(trig_pulse), 32'(exp_pulse));
   endtask

   task automatic t_reset();
      chk("R1 pulse at reset", 32'(trig_pulse), 0);
      chk("R1 fired at reset", 32'(fired), 0);
      send(16'hFFFF, 1'b1, 1'b0, "R1 disarmed ignores sample");
   endtask

   task automatic t_defaults();
      do_arm();
      send(16'hABCD, 1'b1, 1'b1, "R1 default tables fire");
      chk("R7 fired set", 32'(fired), 1);
      chk("R9 pos zero", 32'(trig_pos), 0);
   endtask

   task automatic t_pattern();
      build(16'h0020, 16'h1020, -1, -1);
      load_tables();
      set_glue(16'hFFFF);
      do_arm();
      send(16'h0000, 1'b1, 1'b0, "R4 ch5 low");
      send(16'h1020, 1'b1, 1'b0, "R4 ch12 high");
      send(16'h0000, 1'b1, 1'b0, "R4 no match");
      send(16'h0020, 1'b1, 1'b1, "R4 pattern match");
      chk("R9 pattern pos", 32'(trig_pos), 3);
      send(16'h0020, 1'b1, 1'b0, "R8 no second pulse");
      chk("R8 fired held", 32'(fired), 1);
      chk("R8 pos held", 32'(trig_pos), 3);
   endtask

   task automatic t_invalid();
      do_arm();
      send(16'h0020, 1'b0, 1'b0, "R9 invalid sample ignored");
      send(16'h0000, 1'b1, 1'b0, "R9 no match");
      send(16'h0020, 1'b1, 1'b1, "R9 match after invalid");
      chk("R9 invalid not counted", 32'(trig_pos), 1);
   endtask

   task automatic t_rise();
      build(16'h0000, 16'h0000, 2, -1);
      load_tables();
      set_glue(glue_of(1'b1, 1'b0));
      do_arm();
      send(16'h0004, 1'b1, 1'b0, "R5 first sample no edge");
      send(16'h0004, 1'b1, 1'b0, "R5 steady high");
      send(16'h0000, 1'b1, 1'b0, "R5 fall not rise");
      send(16'h0004, 1'b1, 1'b1, "R5 rise fires");
      chk("R5 rise pos", 32'(trig_pos), 3);
   endtask

   task automatic t_fall_or();
      build(16'h0000, 16'h0000, 2, 9);
      load_tables();
      set_glue(glue_of(1'b1, 1'b1));
      do_arm();
      send(16'h0200, 1'b1, 1'b0, "R11 first sample");
      send(16'h0200, 1'b1, 1'b0, "R11 steady");
      send(16'h0000, 1'b1, 1'b1, "R11 fall on second detector");
      chk("R11 fall pos", 32'(trig_pos), 2);
   endtask

   task automatic t_combined();
      build(16'h8000, 16'h8000, 2, -1);
      load_tables();
      set_glue(glue_of(1'b1, 1'b0));
      do_arm();
      send(16'h0000, 1'b1, 1'b0, "R6 idle");
      send(16'h0004, 1'b1, 1'b0, "R6 edge without pattern");
      send(16'h8000, 1'b1, 1'b0, "R6 pattern without edge");
      send(16'h8004, 1'b1, 1'b1, "R6 edge and pattern");
      chk("R6 pos", 32'(trig_pos), 3);
   endtask

   task automatic t_select();
      build(16'h0000, 16'h0000, -1, -1);
      load_tables();
      set_glue(16'hFFFF);
      @(negedge clk);
      stg_we   = 1'b1;
      stg_data = 12'h000;
      @(negedge clk);
      stg_we   = 1'b0;
      sel_we   = 1'b1;
      sel_data = 8'h25;
      @(negedge clk);
      sel_we = 1'b0;
      do_arm();
      send(16'h5555, 1'b1, 1'b1, "R3 wrong tag ignored");
      @(negedge clk);
      sel_we   = 1'b1;
      sel_data = 8'h35;
      @(negedge clk);
      sel_we = 1'b0;
      do_arm();
      send(16'h5555, 1'b1, 1'b0, "R2 entry 5 cleared");
      send(16'h4444, 1'b1, 1'b1, "R2 other entry open");
      chk("R2 pos", 32'(trig_pos), 1);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_defaults();
      t_pattern();
      t_invalid();
      t_rise();
      t_fall_or();
      t_combined();
      t_select();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule